// File: doc/BRIEF.md
# Serial EEPROM Status Register and Write Guard

This block keeps the control state of a small serial EEPROM and decides, cycle by cycle, whether a write may proceed. It holds the write-enable latch, a two-bit protection span code and a hardware-lock enable bit. It combines them with the active-low write-protect pin to produce one grant for status register writes and one for memory array writes. The serial front end feeds it decoded command strobes and the received status byte. It also feeds it the chip-select level, the busy flag of the program engine, and the start address of an array write.

A status write is staged when its data byte arrives. It takes effect only on the rising edge of chip select. If the write-protect pin drops first while the lock is enabled, the staged write is dropped. A granted write, to the array or to the status register, raises a one-cycle program start pulse and clears the write-enable latch. A denied write changes nothing and starts nothing. The protection span state resets to zero, because non-volatile retention is outside this block.

Top module: `spi_eeprom_wp_guard`

## Requirements
- R1: The status byte is {wpen, 3'b000, span[1], span[0], wel, rdy}, where bit 7 is the lock enable, bits 3:2 are the span code, bit 1 is the write-enable latch and bit 0 follows busy_i. After reset the byte reads 8'h00, both grants are 0 and prog_start_o is 0.
- R2: A wren_i pulse sets the write-enable latch and a wrdi_i pulse clears it, visible one cycle later. Both pulses are ignored while busy_i is 1.
- R3: A committed status write loads only bits 7, 3 and 2 from the received byte and clears the write-enable latch. Bits 6:4 stay 0 and bit 0 keeps following busy_i.
- R4: sr_grant_o is 1 only when the write-enable latch is 1 and busy_i is 0. A status write attempted with the latch at 0 changes nothing.
- R5: With the lock enable at 1 and wp_ni low, sr_grant_o is 0 and bits 7, 3 and 2 cannot change.
- R6: arr_grant_o is 0 for a start address in the protected span. Span 0 protects nothing. Span 1 protects the top quarter (the two address MSBs both 1). Span 2 protects the top half (address MSB 1). Span 3 protects every address. These rules hold whatever the state of wp_ni and the latch.
- R7: While the hardware lock is active, an unprotected start address is still granted when the latch is 1 and busy_i is 0.
- R8: If wp_ni goes low with the lock enable at 1 while cs_ni is still low after the status byte was staged, the write is cancelled. The status byte is unchanged, the latch stays set and no program pulse follows.
- R9: Once a status write has committed on the rising edge of chip select, a later low level on wp_ni does not alter the stored value.
- R10: A granted array commit or status commit gives prog_start_o = 1 for exactly one cycle after the commit edge, and clears the latch. A denied commit gives no pulse and leaves the latch and the status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select level, active low |
| wp_ni | input | 1 | Write-protect pin, active low |
| busy_i | input | 1 | Program cycle in progress |
| wren_i | input | 1 | Write-enable command strobe |
| wrdi_i | input | 1 | Write-disable command strobe |
| wrsr_load_i | input | 1 | Status data byte received strobe |
| wrsr_data_i | input | 8 | Received status data byte |
| arr_commit_i | input | 1 | Array write sequence closed by chip select rising |
| arr_addr_i | input | ADDR_W | Start address of the array write |
| status_o | output | 8 | Assembled status byte |
| sr_grant_o | output | 1 | Status register write allowed |
| arr_grant_o | output | 1 | Array write to arr_addr_i allowed |
| prog_start_o | output | 1 | One-cycle program cycle start |

## Verification
The bench builds the block with the default 12-bit address. At that width the quarter and half span edges fall on 0xC00 and 0x800, so the addresses on either side of each edge can be named directly. A vector table sweeps the span codes against addresses just below, at and above those edges, including a page start inside the top page. Directed sequences then cover the latch under busy, the hardware lock, the cancelled status write and the commit pulse.

// File: rtl/eeprom_prot_pkg.sv
package eeprom_prot_pkg;
  localparam int SR_W      = 8;
  localparam int SR_LOCK   = 7;
  localparam int SR_SPAN_H = 3;
  localparam int SR_SPAN_L = 2;
  localparam int SR_WEL    = 1;
  localparam int SR_RDY    = 0;

  typedef enum logic [1:0] {
    SPAN_NONE    = 2'd0,
    SPAN_QUARTER = 2'd1,
    SPAN_HALF    = 2'd2,
    SPAN_ALL     = 2'd3
  } prot_span_e;
endpackage

// File: rtl/prot_span_decode.sv
module prot_span_decode
  import eeprom_prot_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  prot_span_e        span_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              locked_o
);
  localparam int MSB = ADDR_W - 1;

  always_comb begin
    unique case (span_i)
      SPAN_NONE:    locked_o = 1'b0;
      SPAN_QUARTER: locked_o = &addr_i[MSB -: 2];
      SPAN_HALF:    locked_o = addr_i[MSB];
      default:      locked_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/sr_write_tracker.sv
module sr_write_tracker
  import eeprom_prot_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_ni,
  input  logic            load_i,
  input  logic            grant_i,
  input  logic            hw_lock_i,
  input  logic            busy_i,
  input  logic [SR_W-1:0] data_i,
  output logic            commit_o,
  output logic [SR_W-1:0] data_o
);
  logic cs_q, pend_q, cs_rise;

  assign cs_rise  = cs_ni & ~cs_q;
  assign commit_o = pend_q & cs_rise & ~hw_lock_i & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      pend_q <= 1'b0;
      data_o <= '0;
    end else begin
      cs_q <= cs_ni;
      if (load_i && grant_i && !cs_ni) begin
        pend_q <= 1'b1;
        data_o <= data_i;
      end else if (pend_q && !cs_ni && hw_lock_i) begin
        pend_q <= 1'b0;  // pin dropped before deselect
      end else if (cs_rise) begin
        pend_q <= 1'b0;
      end
    end
  end

  a_r8_abort_on_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !cs_ni && hw_lock_i && !load_i) |=> !pend_q);
endmodule

// File: rtl/status_core.sv
module status_core
  import eeprom_prot_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            busy_i,
  input  logic            wel_set_i,
  input  logic            wel_clr_i,
  input  logic            sr_commit_i,
  input  logic [SR_W-1:0] sr_data_i,
  input  logic            arr_commit_i,
  output logic            wel_o,
  output logic            lock_en_o,
  output prot_span_e      span_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_o     <= 1'b0;
      lock_en_o <= 1'b0;
      span_o    <= SPAN_NONE;
    end else if (!busy_i) begin
      if (sr_commit_i) begin
        lock_en_o <= sr_data_i[SR_LOCK];
        span_o    <= prot_span_e'(sr_data_i[SR_SPAN_H:SR_SPAN_L]);
      end
      if (sr_commit_i || arr_commit_i) wel_o <= 1'b0;
      else if (wel_set_i)              wel_o <= 1'b1;
      else if (wel_clr_i)              wel_o <= 1'b0;
    end
  end

  a_r2_wel_frozen_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(wel_o));
endmodule

// File: rtl/spi_eeprom_wp_guard.sv
module spi_eeprom_wp_guard
  import eeprom_prot_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wp_ni,
  input  logic              busy_i,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_load_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic              arr_commit_i,
  input  logic [ADDR_W-1:0] arr_addr_i,
  output logic [7:0]        status_o,
  output logic              sr_grant_o,
  output logic              arr_grant_o,
  output logic              prog_start_o
);
  logic            wel, lock_en, hw_lock, locked;
  logic            sr_commit, arr_go;
  logic [SR_W-1:0] staged;
  prot_span_e      span;

  assign hw_lock     = lock_en & ~wp_ni;
  assign sr_grant_o  = wel & ~busy_i & ~hw_lock;
  assign arr_grant_o = wel & ~busy_i & ~locked;
  assign arr_go      = arr_commit_i & arr_grant_o;

  prot_span_decode #(.ADDR_W(ADDR_W)) u_span (
    .span_i  (span),
    .addr_i  (arr_addr_i),
    .locked_o(locked)
  );

  sr_write_tracker u_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_ni    (cs_ni),
    .load_i   (wrsr_load_i),
    .grant_i  (sr_grant_o),
    .hw_lock_i(hw_lock),
    .busy_i   (busy_i),
    .data_i   (wrsr_data_i),
    .commit_o (sr_commit),
    .data_o   (staged)
  );

  status_core u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (busy_i),
    .wel_set_i   (wren_i),
    .wel_clr_i   (wrdi_i),
    .sr_commit_i (sr_commit),
    .sr_data_i   (staged),
    .arr_commit_i(arr_go),
    .wel_o       (wel),
    .lock_en_o   (lock_en),
    .span_o      (span)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prog_start_o <= 1'b0;
    else         prog_start_o <= sr_commit | arr_go;
  end

  always_comb begin
    status_o            = '0;
    status_o[SR_LOCK]   = lock_en;
    status_o[SR_SPAN_H] = span[1];
    status_o[SR_SPAN_L] = span[0];
    status_o[SR_WEL]    = wel;
    status_o[SR_RDY]    = busy_i;
  end

  a_r5_lock_holds_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_lock |=> ($stable(status_o[SR_LOCK]) && $stable(status_o[SR_SPAN_H:SR_SPAN_L])));
  a_r6_full_span_denies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[SR_SPAN_H:SR_SPAN_L] == 2'b11) |-> !arr_grant_o);
  a_r10_pulse_consumes_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |-> ($past(status_o[SR_WEL]) && !status_o[SR_WEL]));
  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |=> !prog_start_o);
endmodule

// File: tb/spi_eeprom_wp_guard_test.sv
module spi_eeprom_wp_guard_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1, wp_ni = 1'b1, busy_i = 1'b0;
  logic        wren_i = 1'b0, wrdi_i = 1'b0, wrsr_load_i = 1'b0, arr_commit_i = 1'b0;
  logic [7:0]  wrsr_data_i = '0;
  logic [11:0] arr_addr_i = '0;
  logic [7:0]  status_o;
  logic        sr_grant_o, arr_grant_o, prog_start_o;
  int          checks = 0, fails = 0;

  always #4 clk_i = ~clk_i;

  spi_eeprom_wp_guard #(.ADDR_W(12)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .wp_ni(wp_ni), .busy_i(busy_i),
    .wren_i(wren_i), .wrdi_i(wrdi_i), .wrsr_load_i(wrsr_load_i), .wrsr_data_i(wrsr_data_i),
    .arr_commit_i(arr_commit_i), .arr_addr_i(arr_addr_i), .status_o(status_o),
    .sr_grant_o(sr_grant_o), .arr_grant_o(arr_grant_o), .prog_start_o(prog_start_o)
  );

  // {span[1:0], addr[11:0], expected grant}
  localparam logic [14:0] VEC [8] = '{
    {2'b00, 12'hFFF, 1'b1}, {2'b01, 12'hBFF, 1'b1}, {2'b01, 12'hC00, 1'b0},
    {2'b10, 12'h7FF, 1'b1}, {2'b10, 12'h800, 1'b0}, {2'b10, 12'hC20, 1'b0},
    {2'b11, 12'h000, 1'b0}, {2'b01, 12'hFE0, 1'b0}
  };

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wren();
    wren_i = 1'b1; step(); wren_i = 1'b0;
  endtask

  // stage a status byte and deselect; commit happens on the deselect edge
  task automatic wrsr(input logic [7:0] d);
    cs_ni = 1'b0; wrsr_load_i = 1'b1; wrsr_data_i = d; step();
    wrsr_load_i = 1'b0; cs_ni = 1'b1; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    step(); step();
    chk("R1 reset status", status_o, 8'h00);
    chk("R1 reset grants", {6'b0, sr_grant_o, arr_grant_o}, 8'h00);
    chk("R1 reset pulse", {7'b0, prog_start_o}, 8'h00);
    rst_ni = 1'b1; step();

    for (int i = 0; i < 8; i++) begin
      wren();
      wrsr({4'b0000, VEC[i][14:13], 2'b00});
      step();
      wren();
      arr_addr_i = VEC[i][12:1]; #1;
      chk($sformatf("R6 span vector %0d", i), {7'b0, arr_grant_o}, {7'b0, VEC[i][0]});
    end
    wrsr(8'h00); wrdi_i = 1'b1; step(); wrdi_i = 1'b0;  // span 0 needs latch set: redo
    wren(); wrsr(8'h00); step(); wrdi_i = 1'b1; step(); wrdi_i = 1'b0;
    chk("R2 cleared baseline", status_o, 8'h00);

    wren();
    chk("R2 wren sets latch", status_o, 8'h02);
    wrdi_i = 1'b1; step(); wrdi_i = 1'b0;
    chk("R2 wrdi clears latch", status_o, 8'h00);
    busy_i = 1'b1; wren_i = 1'b1; step(); wren_i = 1'b0; #1;
    chk("R2 wren ignored when busy, R1 rdy", status_o, 8'h01);
    busy_i = 1'b0; #1;

    chk("R4 no grant without latch", {7'b0, sr_grant_o}, 8'h00);
    wrsr(8'h8C);
    chk("R4 write without latch ignored", status_o, 8'h00);
    chk("R10 no pulse on denied write", {7'b0, prog_start_o}, 8'h00);

    wren();
    wrsr(8'hFF);
    chk("R3 only bits 7,3,2 loaded, latch cleared", status_o, 8'h8C);
    chk("R10 pulse after commit", {7'b0, prog_start_o}, 8'h01);
    step();
    chk("R10 pulse lasts one cycle", {7'b0, prog_start_o}, 8'h00);

    wren(); wrsr(8'h80); step();
    chk("R3 lock enable with span 0", status_o, 8'h80);
    wp_ni = 1'b0; wren(); #1;
    chk("R5 status grant blocked by lock", {7'b0, sr_grant_o}, 8'h00);
    arr_addr_i = 12'h000; #1;
    chk("R7 unprotected array still granted", {7'b0, arr_grant_o}, 8'h01);
    wrsr(8'h8C);
    chk("R5 locked status write ignored", status_o, 8'h82);
    chk("R10 no pulse when locked", {7'b0, prog_start_o}, 8'h00);

    wp_ni = 1'b1;
    cs_ni = 1'b0; wrsr_load_i = 1'b1; wrsr_data_i = 8'h88; step();
    wrsr_load_i = 1'b0; wp_ni = 1'b0; step();
    cs_ni = 1'b1; step();
    chk("R8 cancelled write keeps status", status_o, 8'h82);
    chk("R8 cancelled write no pulse", {7'b0, prog_start_o}, 8'h00);

    wp_ni = 1'b1; #1;
    wrsr(8'h84);
    wp_ni = 1'b0; step(); step();
    chk("R9 committed value kept after pin low", status_o, 8'h84);

    wren();
    arr_addr_i = 12'hC00; arr_commit_i = 1'b1; step(); arr_commit_i = 1'b0; #1;
    chk("R10 protected array commit denied", {status_o[7:1], prog_start_o}, 8'h86 >> 0 & 8'hFE);
    chk("R6 protected address denied under lock", {7'b0, arr_grant_o}, 8'h00);
    arr_addr_i = 12'h100; arr_commit_i = 1'b1; step(); arr_commit_i = 1'b0; #1;
    chk("R10 granted array commit pulses", {7'b0, prog_start_o}, 8'h01);
    chk("R10 granted array commit clears latch", status_o, 8'h84);
    wp_ni = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule